// File: doc/BRIEF.md
# Port-Bound Unified Reservation Station

This block is the scheduling window of an out-of-order core. It holds twenty waiting micro-ops of every operation class in one shared pool and feeds five execution ports. Each micro-op is tied to exactly one port when it is written in. Most classes have only one port that can execute them. The simple integer class can run on either of the two integer ALU ports, so the binder picks one of those two at write time.

Because the port is fixed at write time, issue needs no cross-port assignment. Each port makes its own 1-of-N choice and takes the oldest ready micro-op bound to it. A ready micro-op whose port is stalled waits, even if the other ALU port is idle that cycle.

Source operands wake up when a result tag is broadcast on any of the writeback lanes. An entry leaves the pool at the end of the cycle in which it issues.

Top module: `rsps_top`

## Requirements
- R1: After reset the pool is empty: `alloc_ready` is high and every bit of `iss_valid` is low.
- R2: Operation class codes bind as follows: 1 (FP add), 2 (FP multiply), 3 (integer multiply), 4 (divide) and the unused codes 9 to 15 go to port 0. Code 5 (jump) goes to port 1, code 6 (load address) to port 2, code 7 (store address) to port 3 and code 8 (store data) to port 4.
- R3: Class 0 (simple integer) alternates between port 0 and port 1 on successive accepted class-0 allocations, starting with port 0 after reset. Other classes and refused requests do not advance the alternation.
- R4: An entry is eligible only when both sources are ready. A source is ready if it was flagged ready at allocation, if its tag matched a valid writeback lane in the allocation cycle, or if its tag matches a valid writeback lane in a later cycle. The new readiness takes effect for issue from the following cycle.
- R5: Each port issues at most one micro-op per cycle. `iss_valid[p]` is high exactly when some eligible entry is bound to port p and `port_busy[p]` is low. `iss_tag` lane p, bits [p*TAG_W +: TAG_W], carries that entry's destination tag.
- R6: When several eligible entries are bound to the same port, the one allocated earliest issues first.
- R7: While `port_busy[p]` is high, nothing issues on port p. An entry bound to p never issues on another port, even when a port of the same kind is idle.
- R8: An issued entry is removed at the end of its issue cycle and never issues again.
- R9: When all 20 entries are occupied, `alloc_ready` is low and a request on `alloc_valid` is ignored: no entry is written and the class-0 alternation does not advance.
- R10: All five ports can issue in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_ready | output | 1 | A free entry exists; the request is accepted when both are high |
| alloc_cls | input | 4 | Operation class code |
| alloc_dst | input | TAG_W | Destination tag of the micro-op |
| alloc_src0 | input | TAG_W | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1 | input | TAG_W | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| wb_valid | input | WB_N | Writeback lane valid bits |
| wb_tag | input | WB_N*TAG_W | Writeback lane tags, lane w at [w*TAG_W +: TAG_W] |
| port_busy | input | 5 | Per-port stall from the execution units |
| iss_valid | output | 5 | Per-port issue strobe |
| iss_tag | output | 5*TAG_W | Destination tag issued on each port |

## Verification
A lost wakeup, a wrong port binding or a stale age relation in this block shows up on the issue lanes: the wrong tag leaves on a port, or an expected issue is missing. This is visible in the same cycle the bench model predicts the issue. A slot that is not freed shows either as a repeated tag on the next cycle or as `alloc_ready` dropping early once the pool fills. The model tracks allocation order by sequence number and port binding by class alone, so every cycle's five lanes and the ready flag are compared against it under directed corner cases and long random traffic with stalls.

// File: rtl/rsps_pkg.sv
package rsps_pkg;
   localparam int N_PORTS = 5;
   localparam int PORT_W  = 3;
   localparam int CLS_W   = 4;

   typedef enum logic [CLS_W-1:0] {
      OC_ALU  = 4'd0,
      OC_FADD = 4'd1,
      OC_FMUL = 4'd2,
      OC_IMUL = 4'd3,
      OC_DIV  = 4'd4,
      OC_JMP  = 4'd5,
      OC_LDA  = 4'd6,
      OC_STA  = 4'd7,
      OC_STD  = 4'd8
   } opcls_e;

   // Classes with a single capable port; anything unlisted lands on port 0.
   function automatic logic [PORT_W-1:0] fixed_port(input logic [CLS_W-1:0] c);
      case (c)
         OC_JMP:  return 3'd1;
         OC_LDA:  return 3'd2;
         OC_STA:  return 3'd3;
         OC_STD:  return 3'd4;
         default: return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/rsps_bind.sv
module rsps_bind
   import rsps_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [CLS_W-1:0]  cls,
   output logic [PORT_W-1:0] port
);
   logic alt;
   logic is_alu;

   assign is_alu = (cls == OC_ALU);
   assign port   = is_alu ? PORT_W'(alt) : fixed_port(cls);

   always_ff @(posedge clk) begin
      if (!rst_n)              alt <= 1'b0;
      else if (fire && is_alu) alt <= ~alt;
   end

   AST_ALU_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && is_alu) |=> (port != $past(port) || !is_alu)) else $error("alternation"); // R3
endmodule

// File: rtl/rsps_slot.sv
module rsps_slot
   import rsps_pkg::*;
#(
   parameter int TAG_W = 6,
   parameter int WB_N  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              clr,
   input  logic [PORT_W-1:0] in_port,
   input  logic [TAG_W-1:0]  in_dst,
   input  logic [TAG_W-1:0]  in_s0,
   input  logic              in_r0,
   input  logic [TAG_W-1:0]  in_s1,
   input  logic              in_r1,
   input  logic [WB_N-1:0]   wb_valid,
   input  logic [WB_N*TAG_W-1:0] wb_tag,
   output logic              o_vld,
   output logic              o_elig,
   output logic [PORT_W-1:0] o_port,
   output logic [TAG_W-1:0]  o_dst
);
   logic [TAG_W-1:0] s0, s1;
   logic r0, r1;

   function automatic logic hit(input logic [TAG_W-1:0] t,
                                input logic [WB_N-1:0] v,
                                input logic [WB_N*TAG_W-1:0] tg);
      logic h;
      h = 1'b0;
      for (int w = 0; w < WB_N; w++)
         if (v[w] && tg[w*TAG_W +: TAG_W] == t) h = 1'b1;
      return h;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_vld <= 1'b0; r0 <= 1'b0; r1 <= 1'b0;
         s0 <= '0; s1 <= '0; o_port <= '0; o_dst <= '0;
      end else if (wr) begin
         o_vld  <= 1'b1;
         o_port <= in_port;
         o_dst  <= in_dst;
         s0     <= in_s0;
         s1     <= in_s1;
         r0     <= in_r0 | hit(in_s0, wb_valid, wb_tag);
         r1     <= in_r1 | hit(in_s1, wb_valid, wb_tag);
      end else begin
         if (clr) o_vld <= 1'b0;
         if (!r0 && hit(s0, wb_valid, wb_tag)) r0 <= 1'b1;
         if (!r1 && hit(s1, wb_valid, wb_tag)) r1 <= 1'b1;
      end
   end

   assign o_elig = o_vld & r0 & r1;

   AST_SRC0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && r0) |=> (!o_vld || r0)) else $error("src0 lost"); // R4
   AST_SRC1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (o_vld && r1) |=> (!o_vld || r1)) else $error("src1 lost"); // R4
   AST_FREED_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr) |=> !o_vld) else $error("not freed"); // R8
endmodule

// File: rtl/rsps_age.sv
module rsps_age #(
   parameter int N = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   alloc_oh,
   input  logic [N-1:0]   vld,
   output logic [N*N-1:0] older   // older[i*N+j]: entry j predates entry i
);
   always_ff @(posedge clk) begin
      if (!rst_n) older <= '0;
      else begin
         for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
               if (alloc_oh[i])      older[i*N+j] <= vld[j] && (i != j);
               else if (alloc_oh[j]) older[i*N+j] <= 1'b0;
      end
   end
endmodule

// File: rtl/rsps_pick.sv
module rsps_pick #(
   parameter int N = 20
) (
   input  logic [N-1:0]   req,
   input  logic [N*N-1:0] older,
   output logic [N-1:0]   grant
);
   always_comb begin
      for (int i = 0; i < N; i++)
         grant[i] = req[i] && ((req & older[i*N +: N]) == '0);
   end
endmodule

// File: rtl/rsps_top.sv
module rsps_top
   import rsps_pkg::*;
#(
   parameter int ENTRIES = 20,
   parameter int TAG_W   = 6,
   parameter int WB_N    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid,
   output logic                     alloc_ready,
   input  logic [CLS_W-1:0]         alloc_cls,
   input  logic [TAG_W-1:0]         alloc_dst,
   input  logic [TAG_W-1:0]         alloc_src0,
   input  logic                     alloc_src0_rdy,
   input  logic [TAG_W-1:0]         alloc_src1,
   input  logic                     alloc_src1_rdy,
   input  logic [WB_N-1:0]          wb_valid,
   input  logic [WB_N*TAG_W-1:0]    wb_tag,
   input  logic [N_PORTS-1:0]       port_busy,
   output logic [N_PORTS-1:0]       iss_valid,
   output logic [N_PORTS*TAG_W-1:0] iss_tag
);
   initial begin
      assert (ENTRIES >= 2 && TAG_W >= 1 && WB_N >= 1)
         else $fatal(1, "rsps_top: bad parameters");
   end

   logic [ENTRIES-1:0]         vld, elig, clr, alloc_oh;
   logic [PORT_W-1:0]          ent_port [ENTRIES];
   logic [TAG_W-1:0]           ent_dst  [ENTRIES];
   logic [ENTRIES*ENTRIES-1:0] older;
   logic [ENTRIES-1:0]         grant    [N_PORTS];
   logic [PORT_W-1:0]          new_port;
   logic                       fire;

   assign alloc_ready = ~&vld;
   assign fire        = alloc_valid & alloc_ready;

   // lowest-numbered free slot receives the new micro-op
   always_comb begin
      alloc_oh = '0;
      for (int i = ENTRIES-1; i >= 0; i--)
         if (!vld[i]) alloc_oh = ENTRIES'(1) << i;
      if (!fire) alloc_oh = '0;
   end

   rsps_bind u_bind (.clk, .rst_n, .fire, .cls(alloc_cls), .port(new_port));

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      rsps_slot #(.TAG_W(TAG_W), .WB_N(WB_N)) u_slot (
         .clk, .rst_n,
         .wr(alloc_oh[e]), .clr(clr[e]),
         .in_port(new_port), .in_dst(alloc_dst),
         .in_s0(alloc_src0), .in_r0(alloc_src0_rdy),
         .in_s1(alloc_src1), .in_r1(alloc_src1_rdy),
         .wb_valid, .wb_tag,
         .o_vld(vld[e]), .o_elig(elig[e]),
         .o_port(ent_port[e]), .o_dst(ent_dst[e]));
   end

   rsps_age #(.N(ENTRIES)) u_age (.clk, .rst_n, .alloc_oh, .vld, .older);

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [ENTRIES-1:0] req;
      logic [TAG_W-1:0]   tag;

      always_comb begin
         for (int i = 0; i < ENTRIES; i++)
            req[i] = elig[i] && (ent_port[i] == PORT_W'(p)) && !port_busy[p];
      end

      rsps_pick #(.N(ENTRIES)) u_pick (.req, .older, .grant(grant[p]));

      always_comb begin
         tag = '0;
         for (int i = 0; i < ENTRIES; i++)
            if (grant[p][i]) tag = tag | ent_dst[i];
      end

      assign iss_valid[p]               = |grant[p];
      assign iss_tag[p*TAG_W +: TAG_W]  = tag;

      AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(grant[p])) else $error("multi grant"); // R5
      AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         port_busy[p] |-> !iss_valid[p]) else $error("busy issue"); // R7
   end

   always_comb begin
      clr = '0;
      for (int p = 0; p < N_PORTS; p++) clr = clr | grant[p];
   end

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (&vld) |-> (!alloc_ready && alloc_oh == '0)) else $error("full accept"); // R9
   AST_RESET_EMPTY: assert property (@(posedge clk)
      !rst_n |=> (iss_valid == '0 || !rst_n)) else $error("reset issue"); // R1
endmodule

// File: tb/sim_rsps_top.sv
module sim_rsps_top;
   localparam int NE = 20, TW = 6, WN = 2, NP = 5;

   logic clk = 1'b0;
   logic rst_n;
   logic alloc_valid, alloc_src0_rdy, alloc_src1_rdy;
   logic alloc_ready;
   logic [3:0] alloc_cls;
   logic [TW-1:0] alloc_dst, alloc_src0, alloc_src1;
   logic [WN-1:0] wb_valid;
   logic [WN*TW-1:0] wb_tag;
   logic [NP-1:0] port_busy, iss_valid;
   logic [NP*TW-1:0] iss_tag;

   always #5 clk = ~clk;

   rsps_top u0 (.*);

   // reference model: unordered slots with allocation sequence numbers
   bit m_v [NE]; bit m_r0 [NE]; bit m_r1 [NE];
   int m_port [NE]; int m_dst [NE]; int m_s0 [NE]; int m_s1 [NE]; int m_seq [NE];
   int seq_ctr = 0; bit m_alt = 0;
   int n_vec = 0, n_bad = 0, dctr = 0;

   function automatic int exp_port(int c);
      if (c == 0) return int'(m_alt);
      case (c) 5: return 1; 6: return 2; 7: return 3; 8: return 4; default: return 0; endcase
   endfunction

   function automatic bit wb_hit(int t);
      for (int w = 0; w < WN; w++)
         if (wb_valid[w] && int'(wb_tag[w*TW +: TW]) == t) return 1'b1;
      return 1'b0;
   endfunction

   task automatic step(string lbl);
      int best [NP];
      int cnt;
      bit exp_rdy;
      #1;
      cnt = 0;
      for (int k = 0; k < NE; k++) if (m_v[k]) cnt++;
      exp_rdy = (cnt < NE);
      n_vec++;
      if (alloc_ready !== exp_rdy) begin
         n_bad++;
         $display("FAIL %s alloc_ready act=%0b exp=%0b", lbl, alloc_ready, exp_rdy);
      end
      for (int p = 0; p < NP; p++) begin
         best[p] = -1;
         if (!port_busy[p])
            for (int k = 0; k < NE; k++)
               if (m_v[k] && m_r0[k] && m_r1[k] && m_port[k] == p &&
                   (best[p] < 0 || m_seq[k] < m_seq[best[p]])) best[p] = k;
         if (iss_valid[p] !== (best[p] >= 0)) begin
            n_bad++;
            $display("FAIL %s port%0d iss_valid act=%0b exp=%0b", lbl, p, iss_valid[p], best[p] >= 0);
         end else if (best[p] >= 0 && int'(iss_tag[p*TW +: TW]) != m_dst[best[p]]) begin
            n_bad++;
            $display("FAIL %s port%0d iss_tag act=%0d exp=%0d", lbl, p, iss_tag[p*TW +: TW], m_dst[best[p]]);
         end
      end
      for (int p = 0; p < NP; p++) if (best[p] >= 0) m_v[best[p]] = 0;
      for (int k = 0; k < NE; k++) if (m_v[k]) begin
         if (!m_r0[k] && wb_hit(m_s0[k])) m_r0[k] = 1;
         if (!m_r1[k] && wb_hit(m_s1[k])) m_r1[k] = 1;
      end
      if (alloc_valid && exp_rdy) begin
         for (int k = 0; k < NE; k++) if (!m_v[k]) begin
            m_v[k] = 1; m_port[k] = exp_port(int'(alloc_cls));
            m_dst[k] = int'(alloc_dst); m_s0[k] = int'(alloc_src0); m_s1[k] = int'(alloc_src1);
            m_r0[k] = alloc_src0_rdy | wb_hit(int'(alloc_src0));
            m_r1[k] = alloc_src1_rdy | wb_hit(int'(alloc_src1));
            m_seq[k] = seq_ctr++;
            break;
         end
         if (alloc_cls == 4'd0) m_alt = ~m_alt;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      alloc_valid = 0; wb_valid = '0;
   endtask

   task automatic put(int cls, int s0, bit r0, int s1, bit r1);
      alloc_valid = 1; alloc_cls = 4'(cls); alloc_dst = TW'(dctr); dctr++;
      alloc_src0 = TW'(s0); alloc_src0_rdy = r0; alloc_src1 = TW'(s1); alloc_src1_rdy = r1;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog R5 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; idle(); port_busy = '0; alloc_cls = 0; alloc_dst = 0;
      alloc_src0 = 0; alloc_src1 = 0; alloc_src0_rdy = 0; alloc_src1_rdy = 0; wb_tag = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step("R1 reset state");
      step("R1 reset state");

      // R3 and R7: two simple ops split over ports 0 and 1, port 0 stalled
      port_busy = 5'b00001;
      put(0, 1, 1, 2, 1); step("R3 alternation");
      put(0, 1, 1, 2, 1); step("R3 alternation");
      idle(); step("R7 bound port busy");
      step("R7 bound port busy");
      port_busy = '0; step("R7 release");
      step("R7 release");

      // R2: every class code
      for (int c = 1; c < 16; c++) begin put(c, 0, 1, 0, 1); step("R2 class binding"); end
      idle(); repeat (4) step("R2 class binding");

      // R4: wakeup later and wakeup in allocation cycle
      put(6, 20, 0, 21, 1); step("R4 not ready");
      idle(); step("R4 not ready"); step("R4 not ready");
      wb_valid = 2'b10; wb_tag = {TW'(20), TW'(0)}; step("R4 wakeup");
      idle(); step("R4 wakeup"); step("R4 wakeup");
      put(7, 22, 0, 23, 0); wb_valid = 2'b11; wb_tag = {TW'(23), TW'(22)}; step("R4 same-cycle wakeup");
      idle(); step("R4 same-cycle wakeup"); step("R4 same-cycle wakeup");

      // R6 and R8: age order on one port
      port_busy = '1;
      for (int k = 0; k < 4; k++) begin put(7, 0, 1, 0, 1); step("R6 oldest first"); end
      idle(); port_busy = '0;
      repeat (6) step("R6 R8 drain in order");

      // R9: fill beyond capacity
      port_busy = '1;
      for (int k = 0; k < 24; k++) begin put(k % 9, 0, 1, 0, 1); step("R9 full stall"); end
      idle(); port_busy = '0;
      repeat (12) step("R9 drain");

      // R10: all five ports at once
      port_busy = '1;
      put(1, 0, 1, 0, 1); step("R10 five wide");
      put(5, 0, 1, 0, 1); step("R10 five wide");
      put(6, 0, 1, 0, 1); step("R10 five wide");
      put(7, 0, 1, 0, 1); step("R10 five wide");
      put(8, 0, 1, 0, 1); step("R10 five wide");
      idle(); port_busy = '0; step("R10 five wide");
      step("R10 five wide");

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 3) != 0)
            put($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 1),
                $urandom_range(0, 15), $urandom_range(0, 1));
         else alloc_valid = 0;
         wb_valid = WN'($urandom_range(0, 3));
         wb_tag = {TW'($urandom_range(0, 15)), TW'($urandom_range(0, 15))};
         for (int p = 0; p < NP; p++) port_busy[p] = ($urandom_range(0, 3) == 0);
         step("R4 R5 R6 R7 R8 random");
      end
      idle(); port_busy = '0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule